// File: doc/BRIEF.md
# Buffered ADC Trigger Delay Generator

This block raises start pulses for an analog-to-digital converter at a programmable point of a PWM carrier. It watches an external timer count that either ramps up and down in a triangle (center-aligned complementary PWM) or simply counts up. Two independent trigger channels, A and B, each compare the count against an active compare register. A pulse is raised when the two are equal and the present count direction is enabled for that channel.

Software never writes the active compare value directly. It writes a per-channel buffer, and the buffer is copied into the compare register on a selectable reload event. In triangle mode that event is the crest, the trough or both. In the up-count modes it is an external period-compare match. A 16-bit control word holds the reload selection, four direction enables and four stored link enables for interrupt skipping. The skipping logic itself lies outside the block.

Because the compare register only changes at a reload event, loading 0 at a trough or the peak value at a crest removes the trigger for the half period that follows. Placement in time therefore lags a buffer write by up to one half period.

Top module: `adc_trig_delay`

## Requirements
- R1: After reset the control word reads 0x0000. Bits 13:8 always read 0 and ignore writes. The other bits hold what was written from the cycle after the write: [15:14] reload select, [7] up-enable A, [6] down-enable A, [5] up-enable B, [4] down-enable B, [3:0] skip-link enables.
- R2: In triangle mode the reload select works as follows: 00 never reloads, 01 reloads at a crest event, 10 at a trough event and 11 at both. A reload copies the buffer into the compare register at that edge.
- R3: In triangle mode an up-enable allows a trigger only while counting up with 0 <= count <= peak-1. A down-enable allows one only while counting down with 1 <= count <= peak.
- R4: A channel triggers when the count equals its active compare value inside an enabled window. Channels A and B are evaluated independently.
- R5: A buffer write leaves the active compare value unchanged until a reload event occurs.
- R6: Outside triangle mode an up-enable triggers on any compare match in either direction, and the down-enables have no effect.
- R7: Outside triangle mode a nonzero reload select copies the buffer on the period-match input. Code 00 never reloads.
- R8: With up-enable set, a 0 reloaded at a trough raises no trigger in the up-count half that immediately follows. The next trough with compare value 0 does trigger.
- R9: With down-enable set, the peak value reloaded at a crest raises no trigger in the down-count half that immediately follows. The next crest does trigger.
- R10: Each trigger is a one-cycle pulse, registered one cycle after the matching input cycle. A count held at the compare value gives only one pulse.
- R11: After reset both buffers, both compare registers and both trigger outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tri_mode | input | 1 | 1: triangle (complementary PWM) counting, 0: up-count modes |
| cnt | input | CNT_W | Timer count value |
| cnt_down | input | 1 | 1 while the timer counts down |
| peak | input | CNT_W | Triangle peak value |
| crest_evt | input | 1 | One-cycle strobe at the crest |
| trough_evt | input | 1 | One-cycle strobe at the trough |
| per_match | input | 1 | Period-compare match strobe used outside triangle mode |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| buf_a_we | input | 1 | Channel A buffer write strobe |
| buf_a_wdata | input | CNT_W | Channel A buffer write data |
| buf_b_we | input | 1 | Channel B buffer write strobe |
| buf_b_wdata | input | CNT_W | Channel B buffer write data |
| ctl_rdata | output | 16 | Current control word |
| cmp_a | output | CNT_W | Channel A active compare value |
| cmp_b | output | CNT_W | Channel B active compare value |
| trig_a | output | 1 | Channel A converter start pulse |
| trig_b | output | 1 | Channel B converter start pulse |

## Verification
The assertions assume that the timer inputs behave like a real carrier. In triangle mode the count stays within 0..peak, and the direction flag is low at the trough and high at the crest. Crest and trough strobes come only in the cycle where the count sits at peak or 0. The stimulus follows these rules: every sweep steps the count one value per cycle between 0 and a peak of 10, and each event strobe is raised in that single cycle. Outside triangle mode the down-enables and the upper reload bit are written as 0, except where the bench checks that a down-enable has no effect.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int CTL_W = 16;

    typedef enum logic [1:0] {
        RLD_NONE   = 2'b00,
        RLD_CREST  = 2'b01,
        RLD_TROUGH = 2'b10,
        RLD_BOTH   = 2'b11
    } reload_sel_e;

    typedef struct packed {
        reload_sel_e reload_sel;  // [15:14]
        logic [5:0]  rsvd;        // [13:8]
        logic        up_a;        // [7]
        logic        dn_a;        // [6]
        logic        up_b;        // [5]
        logic        dn_b;        // [4]
        logic [3:0]  skip_link;   // [3:0]
    } ctl_t;

endpackage

// File: rtl/adc_trig_ctlreg.sv
module adc_trig_ctlreg
    import adc_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl
);

    typedef struct packed {
        ctl_t ctl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ctl      = ctl_t'(wdata);
            st_d.ctl.rsvd = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl = st_q.ctl;

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rsvd == 6'd0);

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ctl.up_a == $past(wdata[7])) && (ctl.dn_b == $past(wdata[4])));

endmodule

// File: rtl/adc_trig_chan.sv
module adc_trig_chan
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tri_mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_down,
    input  logic [CNT_W-1:0] peak,
    input  logic             crest_evt,
    input  logic             trough_evt,
    input  logic             per_match,
    input  reload_sel_e      reload_sel,
    input  logic             up_en,
    input  logic             dn_en,
    input  logic             buf_we,
    input  logic [CNT_W-1:0] buf_wdata,
    output logic [CNT_W-1:0] cmp,
    output logic             trig
);

    typedef struct packed {
        logic [CNT_W-1:0] bufv;
        logic [CNT_W-1:0] cmpv;
        logic             hit;
        logic             trig;
    } state_t;

    state_t st_d, st_q;
    logic   reload;
    logic   in_up, in_dn, win_ok;

    always_comb begin
        if (tri_mode)
            reload = (reload_sel[0] && crest_evt) || (reload_sel[1] && trough_evt);
        else
            reload = (reload_sel != RLD_NONE) && per_match;

        in_up  = !cnt_down && (cnt < peak);
        in_dn  = cnt_down && (cnt != '0) && (cnt <= peak);
        win_ok = tri_mode ? ((up_en && in_up) || (dn_en && in_dn)) : up_en;

        st_d      = st_q;
        if (buf_we) st_d.bufv = buf_wdata;
        if (reload) st_d.cmpv = st_q.bufv;
        st_d.hit  = win_ok && (cnt == st_q.cmpv);
        st_d.trig = st_d.hit && !st_q.hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp  = st_q.cmpv;
    assign trig = st_q.trig;

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> cmp == $past(cmp));

    assert_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(cnt) == $past(cmp));

    assert_up_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && $past(tri_mode) && !$past(cnt_down)) |-> ($past(cnt) < $past(peak)));

    assert_down_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && $past(tri_mode) && $past(cnt_down)) |->
            (($past(cnt) != '0) && ($past(cnt) <= $past(peak))));

endmodule

// File: rtl/adc_trig_delay.sv
module adc_trig_delay
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tri_mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_down,
    input  logic [CNT_W-1:0] peak,
    input  logic             crest_evt,
    input  logic             trough_evt,
    input  logic             per_match,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             buf_a_we,
    input  logic [CNT_W-1:0] buf_a_wdata,
    input  logic             buf_b_we,
    input  logic [CNT_W-1:0] buf_b_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic [CNT_W-1:0] cmp_a,
    output logic [CNT_W-1:0] cmp_b,
    output logic             trig_a,
    output logic             trig_b
);

    localparam int NCH = 2;

    ctl_t             ctl;
    logic [NCH-1:0]   up_v, dn_v, we_v, trig_v;
    logic [CNT_W-1:0] wd_v  [NCH];
    logic [CNT_W-1:0] cmp_v [NCH];

    adc_trig_ctlreg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    assign up_v  = {ctl.up_b, ctl.up_a};
    assign dn_v  = {ctl.dn_b, ctl.dn_a};
    assign we_v  = {buf_b_we, buf_a_we};
    assign wd_v[0] = buf_a_wdata;
    assign wd_v[1] = buf_b_wdata;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        adc_trig_chan #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tri_mode   (tri_mode),
            .cnt        (cnt),
            .cnt_down   (cnt_down),
            .peak       (peak),
            .crest_evt  (crest_evt),
            .trough_evt (trough_evt),
            .per_match  (per_match),
            .reload_sel (ctl.reload_sel),
            .up_en      (up_v[ch]),
            .dn_en      (dn_v[ch]),
            .buf_we     (we_v[ch]),
            .buf_wdata  (wd_v[ch]),
            .cmp        (cmp_v[ch]),
            .trig       (trig_v[ch])
        );
    end

    assign ctl_rdata = ctl;
    assign cmp_a     = cmp_v[0];
    assign cmp_b     = cmp_v[1];
    assign trig_a    = trig_v[0];
    assign trig_b    = trig_v[1];

endmodule

// File: tb/adc_trig_delay_tb.sv
module adc_trig_delay_tb;

    localparam int CNT_W = 16;
    localparam logic [CNT_W-1:0] PK = 16'd10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tri_mode = 1'b1;
    logic [CNT_W-1:0] cnt = '0;
    logic             cnt_down = 1'b0;
    logic [CNT_W-1:0] peak = PK;
    logic             crest_evt = 1'b0, trough_evt = 1'b0, per_match = 1'b0;
    logic             ctl_we = 1'b0;
    logic [15:0]      ctl_wdata = '0;
    logic             buf_a_we = 1'b0, buf_b_we = 1'b0;
    logic [CNT_W-1:0] buf_a_wdata = '0, buf_b_wdata = '0;
    logic [15:0]      ctl_rdata;
    logic [CNT_W-1:0] cmp_a, cmp_b;
    logic             trig_a, trig_b;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    adc_trig_delay #(.CNT_W(CNT_W)) u_dut (.*);

    // {down, cnt[15:0], exp_a, exp_b}; cmp A=4 (up-enabled), B=7 (down-enabled), peak 10
    localparam logic [18:0] VEC [0:8] = '{
        {1'b0, 16'd3, 1'b0, 1'b0},
        {1'b0, 16'd4, 1'b1, 1'b0},
        {1'b0, 16'd4, 1'b0, 1'b0},
        {1'b0, 16'd7, 1'b0, 1'b0},
        {1'b1, 16'd7, 1'b0, 1'b1},
        {1'b1, 16'd4, 1'b0, 1'b0},
        {1'b0, 16'd4, 1'b1, 1'b0},
        {1'b1, 16'd7, 1'b0, 1'b1},
        {1'b1, 16'd7, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        crest_evt = 0; trough_evt = 0; per_match = 0;
        ctl_we = 0; buf_a_we = 0; buf_b_we = 0;
    endtask

    task automatic step(input logic d, input logic [CNT_W-1:0] c);
        cnt_down = d; cnt = c;
        tick();
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_we = 1; ctl_wdata = v;
        tick();
    endtask

    task automatic wr_buf(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
        buf_a_we = 1; buf_a_wdata = a; buf_b_we = 1; buf_b_wdata = b;
        tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int miss;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1;
        // R1 / R11 reset state
        check("R1 ctl reset", ctl_rdata, 16'h0000);
        check("R11 cmp_a reset", cmp_a, 0);
        check("R11 cmp_b reset", cmp_b, 0);
        check("R11 trig reset", {trig_a, trig_b}, 0);
        step(0, 5);
        wr_ctl(16'hFFFF);
        check("R1 reserved ignored", ctl_rdata, 16'hC0FF);
        wr_ctl(16'h0000);

        // setup: bf=11, up_a, dn_b; load A=4, B=7 at crest
        wr_ctl(16'hC090);
        wr_buf(4, 7);
        crest_evt = 1; step(1, PK);
        check("R2 crest reload A", cmp_a, 4);
        check("R2 crest reload B", cmp_b, 7);
        wr_ctl(16'h0090);

        // R4 / R10 vector walk
        foreach (VEC[i]) begin
            step(VEC[i][18], VEC[i][17:2]);
            check("R4 vec trig_a", trig_a, VEC[i][1]);
            check("R4 vec trig_b", trig_b, VEC[i][0]);
        end

        // R3 window edges: A=peak, B=0
        wr_ctl(16'h8090);
        wr_buf(PK, 0);
        trough_evt = 1; step(0, 0);
        check("R2 trough reload A", cmp_a, PK);
        check("R2 trough reload B", cmp_b, 0);
        step(0, PK);
        check("R3 up at peak no trig", trig_a, 0);
        step(1, 0);
        check("R3 down at zero no trig", trig_b, 0);
        wr_ctl(16'h00C0);
        step(1, PK);
        check("R3 down at peak trig", trig_a, 1);

        // R2 codes / R5 buffer isolation
        wr_ctl(16'h4000);
        wr_buf(3, 0);
        check("R5 buffer write no effect", cmp_a, PK);
        trough_evt = 1; step(0, 0);
        check("R2 code01 ignores trough", cmp_a, PK);
        crest_evt = 1; step(1, PK);
        check("R2 code01 crest", cmp_a, 3);
        wr_ctl(16'h0000);
        wr_buf(6, 0);
        crest_evt = 1; step(1, PK);
        trough_evt = 1; step(0, 0);
        check("R2 code00 no reload", cmp_a, 3);
        wr_ctl(16'hC000);
        trough_evt = 1; step(0, 0);
        check("R2 code11 trough", cmp_a, 6);

        // R8 trough corner
        wr_ctl(16'h8080);
        wr_buf(0, 0);
        trough_evt = 1; step(0, 0);
        check("R8 trough cycle", trig_a, 0);
        miss = 0;
        for (int c = 1; c < PK; c++) begin step(0, c[CNT_W-1:0]); miss += trig_a; end
        crest_evt = 1; step(1, PK); miss += trig_a;
        for (int c = PK - 1; c > 0; c--) begin step(1, c[CNT_W-1:0]); miss += trig_a; end
        check("R8 no trig after 0 at trough", miss, 0);
        trough_evt = 1; step(0, 0);
        check("R8 next trough fires", trig_a, 1);

        // R9 crest corner
        wr_ctl(16'h4040);
        wr_buf(PK, 0);
        crest_evt = 1; step(1, PK);
        check("R9 crest cycle", trig_a, 0);
        miss = 0;
        for (int c = PK - 1; c > 0; c--) begin step(1, c[CNT_W-1:0]); miss += trig_a; end
        trough_evt = 1; step(0, 0); miss += trig_a;
        for (int c = 1; c < PK; c++) begin step(0, c[CNT_W-1:0]); miss += trig_a; end
        check("R9 no trig after peak at crest", miss, 0);
        crest_evt = 1; step(1, PK);
        check("R9 next crest fires", trig_a, 1);

        // R6 / R7 up-count modes
        tri_mode = 0;
        wr_ctl(16'h4090);
        wr_buf(5, 0);
        per_match = 1; step(0, 20);
        check("R7 period match reload", cmp_a, 5);
        step(1, 5);
        check("R6 fires while down", trig_a, 1);
        step(0, 5);
        check("R10 held count single pulse", trig_a, 0);
        step(0, 6);
        step(0, 5);
        check("R6 fires while up", trig_a, 1);
        step(1, 0);
        check("R6 down-enable no effect", trig_b, 0);
        wr_ctl(16'h0090);
        wr_buf(9, 0);
        per_match = 1; step(0, 20);
        check("R7 code00 no reload", cmp_a, 5);

        summary();
        $finish;
    end

endmodule